// File: doc/BRIEF.md
# Debug Trigger Register File

This block holds the machine-level debug trigger registers of a small RISC-V core. It has a select register and, for each trigger, a control word, a compare word and an auxiliary word. Software reaches them through one register port: an address, a write enable, write data and a combinational read-data output. The block cleans up every control write before storing it. The match type is pinned to address/data match and the debug-ownership bit is cleared. A size code the block cannot honour falls back to "any size". Apart from the size code, only the privilege enables and the load/store/execute bits are kept.

Each trigger's stored control and compare words are always visible on flat output buses, where the address-match logic reads them. A one-cycle change strobe per trigger tells that logic when a trigger's settings actually moved, so it can re-arm. The word width is 32 bits by default. Setting the width parameter to 64 moves the type and debug-ownership fields to the top of the wider word and enables the upper size bits.

Top module: `dbg_trig_csr`

## Requirements
- R1: After reset, every trigger's control word reads as type 2 (type field = 2, every other bit 0). Its compare word and auxiliary word read 0, and the select register reads 0.
- R2: The type field (bits 31:28 when XLEN=32, bits 63:60 when XLEN=64) reads 2 after any control write, whatever type the written value carries.
- R3: The debug-ownership bit directly below the type field (bit 27, or bit 59 when XLEN=64) always reads 0, even after it is written as 1.
- R4: The size code is {hi, lo}: lo is bits 17:16, and hi is bits 22:21 when XLEN=64 or 0 when XLEN=32. Codes 0, 1, 2, 3 and 5 are stored as written. Code 4 and codes 6 to 15 store code 0 (both size fields read 0).
- R5: Of the remaining control bits, only load (bit 0), store (bit 1), execute (bit 2), U (bit 3), S (bit 4) and M (bit 6) keep their written values. All other bits read 0.
- R6: A compare-word write stores all XLEN bits for the selected trigger. Trigger i's control and compare words appear on trig_ctrl and trig_cmp at bit offset i*XLEN.
- R7: Auxiliary-word writes are ignored, and the auxiliary word always reads 0.
- R8: The select register stores and returns every bit written to it.
- R9: While the select register holds a value of 2 or more, the control, compare and auxiliary words read 0, and writes to them change no trigger.
- R10: trigger_changed[i] is high for exactly the one cycle after a write edge that changed trigger i's stored control word or compare word. A write of the value already stored gives no strobe.
- R11: The addresses are 0x7A0 (select), 0x7A1 (control), 0x7A2 (compare) and 0x7A3 (auxiliary), and any other address reads 0. A read returns the current state in the same cycle, and a write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | Register address |
| csr_we | input | 1 | Write enable for the addressed register |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for csr_addr, combinational |
| trig_ctrl | output | NTRIG*XLEN | Stored control word of each trigger |
| trig_cmp | output | NTRIG*XLEN | Stored compare word of each trigger |
| trigger_changed | output | NTRIG | One-cycle strobe per trigger when its settings change |

## Verification
The bench builds the block with XLEN=64 and NTRIG=2. This width is the only setting where the upper size bits exist, so codes 5 (kept) and 4 (dropped) can be reached, together with the type and debug-ownership fields at the top of the wide word. At the default width of 32 the upper size bits do not exist. A behavioural model follows every write, including select values of exactly 2 and all-ones. On every cycle the model is compared with the output buses, the change strobes and the read data.

// File: rtl/dbg_trig_csr.sv
module dbg_trig_csr #(
  parameter int XLEN  = 32,
  parameter int NTRIG = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [11:0]             csr_addr,
  input  logic                    csr_we,
  input  logic [XLEN-1:0]         csr_wdata,
  output logic [XLEN-1:0]         csr_rdata,
  output logic [NTRIG*XLEN-1:0]   trig_ctrl,
  output logic [NTRIG*XLEN-1:0]   trig_cmp,
  output logic [NTRIG-1:0]        trigger_changed
);
  localparam logic [11:0] A_SEL = 12'h7A0;
  localparam logic [11:0] A_CTL = 12'h7A1;
  localparam logic [11:0] A_CMP = 12'h7A2;
  localparam logic [11:0] A_AUX = 12'h7A3;
  localparam int IDXW = (NTRIG > 1) ? $clog2(NTRIG) : 1;
  localparam logic [XLEN-1:0] TYPE_WORD = XLEN'(4'd2) << (XLEN - 4);
  localparam logic [XLEN-1:0] KEEP_MASK = XLEN'(7'h5F);
  localparam logic [XLEN-1:0] SIZE_MASK = (XLEN == 64) ? XLEN'(32'h0063_0000)
                                                       : XLEN'(32'h0003_0000);

  logic [XLEN-1:0] sel_q;
  logic [XLEN-1:0] ctrl_v [NTRIG];
  logic [XLEN-1:0] cmp_v  [NTRIG];
  logic [3:0]      size_code;
  logic            size_ok;
  logic [XLEN-1:0] ctrl_legal;
  logic            avail;
  logic [IDXW-1:0] idx;
  logic            wr_ctl, wr_cmp;

  assign avail      = sel_q < XLEN'(NTRIG);
  assign idx        = sel_q[IDXW-1:0];
  assign wr_ctl     = csr_we && (csr_addr == A_CTL) && avail;
  assign wr_cmp     = csr_we && (csr_addr == A_CMP) && avail;
  assign size_code  = {(XLEN == 64) ? csr_wdata[22:21] : 2'b00, csr_wdata[17:16]};
  assign size_ok    = (size_code <= 4'd3) || (size_code == 4'd5);
  assign ctrl_legal = TYPE_WORD | (size_ok ? (csr_wdata & SIZE_MASK) : '0)
                    | (csr_wdata & KEEP_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             sel_q <= '0;
    else if (csr_we && csr_addr == A_SEL)   sel_q <= csr_wdata;
  end

  for (genvar g = 0; g < NTRIG; g++) begin : g_trig
    logic [XLEN-1:0] c_q, d_q;
    logic            chg_q;
    logic            hit;
    assign hit = (idx == IDXW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q   <= TYPE_WORD;
        d_q   <= '0;
        chg_q <= 1'b0;
      end else begin
        chg_q <= 1'b0;
        if (wr_ctl && hit && ctrl_legal != c_q) begin
          c_q   <= ctrl_legal;
          chg_q <= 1'b1;
        end
        if (wr_cmp && hit && csr_wdata != d_q) begin
          d_q   <= csr_wdata;
          chg_q <= 1'b1;
        end
      end
    end

    assign ctrl_v[g] = c_q;
    assign cmp_v[g]  = d_q;
    assign trig_ctrl[g*XLEN +: XLEN] = c_q;
    assign trig_cmp[g*XLEN +: XLEN]  = d_q;
    assign trigger_changed[g]        = chg_q;
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      A_SEL:   csr_rdata = sel_q;
      A_CTL:   if (avail) csr_rdata = ctrl_v[idx];
      A_CMP:   if (avail) csr_rdata = cmp_v[idx];
      A_AUX:   csr_rdata = '0;
      default: csr_rdata = '0;
    endcase
  end
endmodule

module dbg_trig_csr_chk #(
  parameter int XLEN  = 32,
  parameter int NTRIG = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  csr_we,
  input logic [XLEN-1:0]       sel_q,
  input logic [NTRIG*XLEN-1:0] trig_ctrl,
  input logic [NTRIG*XLEN-1:0] trig_cmp,
  input logic [NTRIG-1:0]      trigger_changed
);
  localparam logic [XLEN-1:0] ALLOWED = (XLEN'(4'hF) << (XLEN - 4)) | XLEN'(7'h5F)
      | ((XLEN == 64) ? XLEN'(32'h0063_0000) : XLEN'(32'h0003_0000));

  for (genvar g = 0; g < NTRIG; g++) begin : g_chk
    logic [XLEN-1:0] c;
    logic [3:0]      code;
    assign c    = trig_ctrl[g*XLEN +: XLEN];
    assign code = {(XLEN == 64) ? c[22:21] : 2'b00, c[17:16]};

    a_r2_type_pinned: assert property (@(posedge clk) disable iff (!rst_n)
      c[XLEN-1 -: 4] == 4'd2);
    a_r3_dmode_clear: assert property (@(posedge clk) disable iff (!rst_n)
      c[XLEN-5] == 1'b0);
    a_r4_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (code <= 4'd3) || (code == 4'd5));
    a_r5_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (c & ~ALLOWED) == '0);
  end

  a_r9_unavail_write: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && sel_q >= XLEN'(NTRIG)) |=> ($stable(trig_ctrl) && $stable(trig_cmp)));
  a_r10_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger_changed != '0) |-> $past(csr_we));
  a_r10_strobe_one: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trigger_changed));
  a_r10_strobe_move: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger_changed != '0) |-> (!$stable(trig_ctrl) || !$stable(trig_cmp)));
endmodule

bind dbg_trig_csr dbg_trig_csr_chk #(.XLEN(XLEN), .NTRIG(NTRIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .sel_q(sel_q),
  .trig_ctrl(trig_ctrl), .trig_cmp(trig_cmp), .trigger_changed(trigger_changed)
);

// File: tb/dbg_trig_csr_bench.sv
module dbg_trig_csr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XL = 64;
  localparam logic [11:0] A_SEL = 12'h7A0, A_CTL = 12'h7A1, A_CMP = 12'h7A2, A_AUX = 12'h7A3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   csr_addr = '0;
  logic          csr_we = 1'b0;
  logic [XL-1:0] csr_wdata = '0;
  logic [XL-1:0] csr_rdata;
  logic [2*XL-1:0] trig_ctrl, trig_cmp;
  logic [1:0]    trigger_changed;

  int errors = 0;
  int checks = 0;

  logic [XL-1:0] ctrl_m [2];
  logic [XL-1:0] cmp_m  [2];
  logic [XL-1:0] sel_m;
  logic [1:0]    chg_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_trig_csr #(.XLEN(XL), .NTRIG(2)) u_dbg_trig_csr (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trig_ctrl(trig_ctrl),
    .trig_cmp(trig_cmp), .trigger_changed(trigger_changed));

  function automatic logic [XL-1:0] legal_m(input logic [XL-1:0] w);
    logic [XL-1:0] r;
    int code;
    code = int'({w[22:21], w[17:16]});
    r = '0;
    r[63:60] = 4'd2;
    if (code == 0 || code == 1 || code == 2 || code == 3 || code == 5) begin
      r[22:21] = w[22:21];
      r[17:16] = w[17:16];
    end
    r[0] = w[0]; r[1] = w[1]; r[2] = w[2]; r[3] = w[3]; r[4] = w[4]; r[6] = w[6];
    return r;
  endfunction

  function automatic logic [XL-1:0] read_m(input logic [11:0] a);
    if (a == A_SEL) return sel_m;
    if (sel_m >= 2) return '0;
    if (a == A_CTL) return ctrl_m[sel_m[0]];
    if (a == A_CMP) return cmp_m[sel_m[0]];
    return '0;
  endfunction

  always @(posedge clk) begin
    logic [XL-1:0] nv;
    if (!rst_n) begin
      ctrl_m[0] = 64'h2 << 60; ctrl_m[1] = 64'h2 << 60;
      cmp_m[0] = '0; cmp_m[1] = '0; sel_m = '0; chg_m = '0;
    end else begin
      chg_m = '0;
      if (csr_we) begin
        if (csr_addr == A_SEL) sel_m = csr_wdata;
        else if (csr_addr == A_CTL && sel_m < 2) begin
          nv = legal_m(csr_wdata);
          if (nv != ctrl_m[sel_m[0]]) begin ctrl_m[sel_m[0]] = nv; chg_m[sel_m[0]] = 1'b1; end
        end else if (csr_addr == A_CMP && sel_m < 2) begin
          if (csr_wdata != cmp_m[sel_m[0]]) begin
            cmp_m[sel_m[0]] = csr_wdata; chg_m[sel_m[0]] = 1'b1;
          end
        end
      end
    end
  end

  task automatic check(input string tag, input logic [2*XL-1:0] act, input logic [2*XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [11:0] a, input logic we, input logic [XL-1:0] d, input string tag);
    @(negedge clk);
    check({tag, " ctrl"}, trig_ctrl, {ctrl_m[1], ctrl_m[0]});
    check({tag, " cmp"}, trig_cmp, {cmp_m[1], cmp_m[0]});
    check({tag, " R10 strobe"}, {126'd0, trigger_changed}, {126'd0, chg_m});
    csr_addr = a; csr_we = we; csr_wdata = d;
    #1;
    check({tag, " rdata"}, {64'd0, csr_rdata}, {64'd0, read_m(a)});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset values through reads
    step(A_CTL, 0, '0, "R1 ctl0");
    step(A_CMP, 0, '0, "R1 cmp0");
    step(A_AUX, 0, '0, "R1 aux0");
    step(A_SEL, 0, '0, "R1 sel");
    step(A_SEL, 1, 64'd1, "R8 sel1");
    step(A_CTL, 0, '0, "R1 ctl1");
    step(A_SEL, 1, 64'd0, "R8 sel0");
    // R2 R3 R5: all ones, code 15 dropped
    step(A_CTL, 1, '1, "R2 R3 R4 all-ones");
    step(A_CTL, 0, '0, "R5 readback 0x5F");
    // R4 code 5 kept, type 5 and dmode set dropped
    step(A_CTL, 1, (64'h5 << 60) | (64'h1 << 59) | 64'h0021_0041, "R4 code5");
    step(A_CTL, 0, '0, "R4 code5 read");
    step(A_CTL, 1, 64'h0020_0005, "R4 code4");
    step(A_CTL, 0, '0, "R4 code4 read");
    step(A_CTL, 1, 64'h0003_0018, "R4 code3");
    step(A_CTL, 1, 64'h0003_0018, "R10 same value");
    step(A_CTL, 0, '0, "R10 no strobe");
    // R6 compare words
    step(A_SEL, 1, 64'd1, "R8 sel1");
    step(A_CMP, 1, 64'hDEAD_BEEF_0123_4567, "R6 cmp1");
    step(A_CMP, 0, '0, "R6 cmp1 read");
    step(A_AUX, 1, '1, "R7 aux write");
    step(A_AUX, 0, '0, "R7 aux read");
    // R9 unavailable
    step(A_SEL, 1, 64'd2, "R9 sel2");
    step(A_CTL, 1, '1, "R9 ctl write");
    step(A_CMP, 1, 64'h1234, "R9 cmp write");
    step(A_CMP, 0, '0, "R9 cmp read");
    step(A_SEL, 1, '1, "R8 all-ones");
    step(A_SEL, 0, '0, "R8 read");
    step(A_CTL, 0, '0, "R9 ctl read");
    step(12'h7A4, 1, '1, "R11 other addr");
    step(12'h7A4, 0, '0, "R11 other read");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [XL-1:0] d;
      a = 12'h7A0 + 12'($urandom_range(0, 4));
      d = {$urandom, $urandom};
      if (a == A_SEL && ($urandom % 4) != 0) d = XL'($urandom_range(0, 2));
      step(a, 1'($urandom % 2), d, "R11 mixed");
    end
    step(A_SEL, 0, '0, "R11 final");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule